// File: doc/BRIEF.md
# Segment protection check unit

This block decides, one request at a time, whether an access under a segmented protection model is permitted. Each request carries a kind (a direct far transfer, a transfer routed through a gate, a data read or a data write) together with the privilege levels that take part in the decision: the current level of the running code, the requested level held in the selector, the gate descriptor's level and the target descriptor's level. It also carries the target's attribute bits: conforming, executable, writable and readable.

The block registers its verdict. A request presented with its strobe in one cycle returns, in the next cycle, a single-cycle valid pulse with exactly one of two flags set: allow, or a general-protection fault. Requests may arrive on every cycle. The block does not look up descriptors, load selectors, follow gates or deliver the exception. The caller supplies the fields and acts on the verdict.

Privilege levels are unsigned, and a smaller number means more privilege (0 is the highest, 3 the lowest at the default width). All comparisons are unsigned.

Top module: `segchk_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after a reset edge, rspValid, rspAllow and rspFault are 0.
- R2: A request with reqValid high at clock edge N makes rspValid high after edge N+1's predecessor, that is, in the cycle that follows edge N. A cycle with reqValid low leaves rspValid low in the following cycle. Requests on consecutive cycles each produce their own pulse. The reqKind encoding is 0 for a direct transfer, 1 for a gated transfer, 2 for a read and 3 for a write.
- R3: While rspValid is high, exactly one of rspAllow and rspFault is high. While rspValid is low, both are low.
- R4: A direct transfer to a non-conforming target (tgtConform=0) is allowed only when curPl equals tgtPl and selRpl is less than or equal to curPl. Otherwise it faults.
- R5: A direct transfer to a conforming target (tgtConform=1) is allowed exactly when tgtPl is less than or equal to curPl, whatever the value of selRpl.
- R6: A gated transfer faults when curPl is greater than gatePl, or when selRpl is greater than gatePl.
- R7: A gated transfer that passes R6 also needs curPl greater than or equal to tgtPl when the target is conforming, and curPl equal to tgtPl when it is not. It is allowed only when every gate check passes.
- R8: A write faults when the target is executable (tgtExec=1), or when it is a data segment with tgtWrite=0. A write to a writable data segment is allowed.
- R9: A read faults only when the target is executable and tgtRead=0. Reads from data segments, and from readable code, are allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 2 | Request kind: 0 direct, 1 gated, 2 read, 3 write |
| curPl | input | PL_W | Current privilege level |
| selRpl | input | PL_W | Requested privilege level of the selector |
| gatePl | input | PL_W | Gate descriptor privilege level |
| tgtPl | input | PL_W | Target descriptor privilege level |
| tgtConform | input | 1 | Target is a conforming segment |
| tgtExec | input | 1 | Target is an executable (code) segment |
| tgtWrite | input | 1 | Target data segment is writable |
| tgtRead | input | 1 | Target code segment is readable |
| rspValid | output | 1 | Verdict valid pulse |
| rspAllow | output | 1 | Access allowed |
| rspFault | output | 1 | General-protection fault |

## Verification
The hardest outcome to reach from the ports is a gated transfer that fails on exactly one of its three checks while the other two pass. The most awkward case is a selector level above the gate level when the current level and the target level otherwise agree, because only the selector check can catch it. The stimulus sweeps every combination of kind, the four privilege levels and the four attribute bits. It mixes runs of back-to-back requests with idle cycles, so that every single-check failure appears both on consecutive cycles and after a gap. A behavioural model compares the result on every clock.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef enum logic [1:0] {
    KIND_DIRECT = 2'd0,
    KIND_GATED  = 2'd1,
    KIND_READ   = 2'd2,
    KIND_WRITE  = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic load;
    logic clear;
  } ctlStrobe_t;

  typedef struct packed {
    logic conform;
    logic exec;
    logic writable;
    logic readable;
  } tgtAttr_t;

endpackage

// File: rtl/segchk_ctrl.sv
module segchk_ctrl
  import segchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  output ctlStrobe_t strobe,
  output logic       rspValid
);

  // a request loads the verdict; an idle cycle clears it
  always_comb begin
    strobe.load  = reqValid && !rst;
    strobe.clear = !reqValid || rst;
  end

  always_ff @(posedge clk) begin
    if (rst) rspValid <= 1'b0;
    else     rspValid <= reqValid;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/segchk_dpath.sv
module segchk_dpath
  import segchk_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  ctlStrobe_t      strobe,
  input  logic [1:0]      reqKind,
  input  logic [PL_W-1:0] curPl,
  input  logic [PL_W-1:0] selRpl,
  input  logic [PL_W-1:0] gatePl,
  input  logic [PL_W-1:0] tgtPl,
  input  tgtAttr_t        attr,
  output logic            allowQ,
  output logic            faultQ
);

  localparam int NUM_GATE_CHECKS = 3;

  logic directOk, readOk, writeOk, verdictOk;
  logic [NUM_GATE_CHECKS-1:0] gatePass;

  // direct far transfer
  always_comb begin
    if (attr.conform) directOk = (tgtPl <= curPl);
    else              directOk = (curPl == tgtPl) && (selRpl <= curPl);
  end

  // gated transfer: every check must pass
  always_comb begin
    gatePass[0] = (curPl <= gatePl);
    gatePass[1] = (selRpl <= gatePl);
    gatePass[2] = attr.conform ? (curPl >= tgtPl) : (curPl == tgtPl);
  end

  // type checks on loaded segments
  always_comb begin
    readOk  = !attr.exec || attr.readable;
    writeOk = !attr.exec && attr.writable;
  end

  always_comb begin
    unique case (reqKind_e'(reqKind))
      KIND_DIRECT: verdictOk = directOk;
      KIND_GATED:  verdictOk = &gatePass;
      KIND_READ:   verdictOk = readOk;
      default:     verdictOk = writeOk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      allowQ <= 1'b0;
      faultQ <= 1'b0;
    end else if (strobe.load) begin
      allowQ <= verdictOk;
      faultQ <= !verdictOk;
    end
  end

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(allowQ && faultQ));

  assert_conform_direct_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && reqKind == KIND_DIRECT && attr.conform)
      |=> (allowQ == ($past(tgtPl) <= $past(curPl))));

  assert_gate_rpl_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && reqKind == KIND_GATED && selRpl > gatePl) |=> faultQ);

  assert_write_code_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && reqKind == KIND_WRITE && attr.exec) |=> faultQ);

endmodule

// File: rtl/segchk_top.sv
module segchk_top
  import segchk_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reqValid,
  input  logic [1:0]      reqKind,
  input  logic [PL_W-1:0] curPl,
  input  logic [PL_W-1:0] selRpl,
  input  logic [PL_W-1:0] gatePl,
  input  logic [PL_W-1:0] tgtPl,
  input  logic            tgtConform,
  input  logic            tgtExec,
  input  logic            tgtWrite,
  input  logic            tgtRead,
  output logic            rspValid,
  output logic            rspAllow,
  output logic            rspFault
);

  ctlStrobe_t strobe;
  tgtAttr_t   attr;

  assign attr = '{conform: tgtConform, exec: tgtExec,
                  writable: tgtWrite, readable: tgtRead};

  segchk_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  segchk_dpath #(.PL_W(PL_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .reqKind (reqKind),
    .curPl   (curPl),
    .selRpl  (selRpl),
    .gatePl  (gatePl),
    .tgtPl   (tgtPl),
    .attr    (attr),
    .allowQ  (rspAllow),
    .faultQ  (rspFault)
  );

  assert_one_flag_R3: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspAllow ^ rspFault));

  assert_quiet_flags_R3: assert property (@(posedge clk) disable iff (rst)
    !rspValid |-> (!rspAllow && !rspFault));

endmodule

// File: tb/tb_segchk_top.sv
module tb_segchk_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic [1:0] curPl = '0, selRpl = '0, gatePl = '0, tgtPl = '0;
  logic tgtConform = 1'b0, tgtExec = 1'b0, tgtWrite = 1'b0, tgtRead = 1'b0;
  logic rspValid, rspAllow, rspFault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  segchk_top dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .curPl(curPl), .selRpl(selRpl), .gatePl(gatePl), .tgtPl(tgtPl),
    .tgtConform(tgtConform), .tgtExec(tgtExec), .tgtWrite(tgtWrite),
    .tgtRead(tgtRead), .rspValid(rspValid), .rspAllow(rspAllow),
    .rspFault(rspFault)
  );

  // behavioural reference: returns 1 when the access is permitted
  function automatic bit refAllow(int kind, int cur, int rpl, int gpl, int tpl,
                                  bit conf, bit ex, bit wr, bit rd);
    case (kind)
      0: return conf ? (tpl <= cur) : (cur == tpl && rpl <= cur);
      1: begin
        if (cur > gpl) return 0;
        if (rpl > gpl) return 0;
        return conf ? (cur >= tpl) : (cur == tpl);
      end
      2: return !(ex && !rd);
      default: return !ex && wr;
    endcase
  endfunction

  function automatic string tagOf(int kind, bit conf);
    case (kind)
      0: return conf ? "R5" : "R4";
      1: return "R6/R7";
      2: return "R9";
      default: return "R8";
    endcase
  endfunction

  // expected responses, pushed at each edge and checked shortly after it
  bit expQ[$];

  always @(posedge clk) begin
    bit sampRst, sampReq, ok;
    int k;
    sampRst = rst;
    sampReq = reqValid;
    k = int'(reqKind);
    ok = refAllow(k, curPl, selRpl, gatePl, tgtPl, tgtConform, tgtExec, tgtWrite, tgtRead);
    #2;
    total++;
    if (sampRst) begin
      if (rspValid || rspAllow || rspFault) begin
        bad++;
        $display("FAIL R1 reset: actual v/a/f=%0b%0b%0b expected 000", rspValid, rspAllow, rspFault);
      end
    end else if (!sampReq) begin
      if (rspValid || rspAllow || rspFault) begin
        bad++;
        $display("FAIL R2/R3 idle: actual v/a/f=%0b%0b%0b expected 000", rspValid, rspAllow, rspFault);
      end
    end else begin
      expQ.push_back(ok);
      if (!rspValid) begin
        bad++;
        $display("FAIL R2 valid: actual 0 expected 1");
        void'(expQ.pop_front());
      end else if (rspAllow == rspFault) begin
        bad++;
        $display("FAIL R3 flags: actual a/f=%0b%0b expected exactly one", rspAllow, rspFault);
        void'(expQ.pop_front());
      end else begin
        bit e;
        e = expQ.pop_front();
        if (rspAllow != e) begin
          bad++;
          $display("FAIL %s kind=%0d cur=%0d rpl=%0d gpl=%0d tpl=%0d c/x/w/r=%0b%0b%0b%0b: actual allow=%0b expected %0b",
                   tagOf(k, tgtConform), k, curPl, selRpl, gatePl, tgtPl,
                   tgtConform, tgtExec, tgtWrite, tgtRead, rspAllow, e);
        end
      end
    end
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // full sweep; every seventh request is followed by an idle cycle
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 256; v++)
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          reqValid   = 1'b1;
          reqKind    = 2'(k);
          curPl      = 2'(v >> 6);
          selRpl     = 2'(v >> 4);
          gatePl     = 2'(v >> 2);
          tgtPl      = 2'(v);
          tgtConform = b[3];
          tgtExec    = b[2];
          tgtWrite   = b[1];
          tgtRead    = b[0];
          n++;
          if (n % 7 == 0) begin
            @(negedge clk);
            reqValid = 1'b0;
          end
        end
    @(negedge clk);
    reqValid = 1'b0;
    // R1: reset in the middle of traffic
    reqValid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule